// File: doc/BRIEF.md
# Timer Event, Alarm and Capture Unit

This block sits beside a free-running 64-bit time counter and turns activity around that counter into events. Two external trigger pins are synchronised to the clock. When the selected edge arrives on a pin, the current counter value is latched into that pin's timestamp register. Two alarm comparators watch the counter and fire once when the time passes a programmed 64-bit value. Pulse strobes from a separate pulse generator are also collected.

All of these sources set bits in a single event register. Software clears a bit by writing a one to it. A mask register with the same bit layout selects which pending events drive the interrupt line. Each alarm also has an output pin that follows its pending event bit, with a programmable polarity.

Configuration goes through a simple write port. Its addresses are: 0 control, 1 event, 2 mask, 3 alarm-1 low half, 4 alarm-1 high half, 5 alarm-2 low half, 6 alarm-2 high half. The timestamps and the event register are presented directly on output ports.

Top module: `tmr_event_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are cleared: the event register, the mask, the control register, both timestamps, and the alarm arming. After that, `irq_o` is 0 and both alarm pins are 0.
- R2: Trigger 1 sets event bit 24 and trigger 2 sets event bit 25. Each records `time_now` into its timestamp only on the active edge. Control bit 8 selects the edge for trigger 1 and control bit 9 for trigger 2 (0 = rising, 1 = falling). An edge of the other direction has no effect.
- R3: A trigger pin passes through two synchronising flops. A pin change driven before clock edge k is captured at edge k+2, together with the value of `time_now` present at that edge.
- R4: A new capture overwrites the timestamp even when the previous event for that trigger is still pending.
- R5: An armed alarm fires when the counter crosses its value in one step. A crossing means the previous cycle's time is below the alarm and the current time is at or above it, so a step larger than 1 still fires. A time that does not cross it never fires, and neither does a time that moves backwards. Alarm 1 sets event bit 16 and alarm 2 sets event bit 17.
- R6: Writing an alarm's high half (address 4 or 6) arms it. The low half is at address 3 or 5. After firing once, the alarm stays disarmed until its high half is written again.
- R7: Writing address 1 clears every event bit written as 1 and leaves bits written as 0 unchanged. A hardware set in the same cycle wins over the clear.
- R8: `irq_o` is 1 exactly when some event bit and the same mask bit (address 2) are both 1.
- R9: Alarm pin i equals its event bit XOR its polarity bit. Control bit 31 is the polarity for alarm 1 and bit 30 for alarm 2.
- R10: A one-cycle strobe on `pulse_in[0]` sets event bit 7 and one on `pulse_in[1]` sets event bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Current counter value |
| trig_in | input | 2 | Asynchronous trigger pins |
| pulse_in | input | 2 | One-cycle pulse strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| evt_o | output | 32 | Event register contents |
| stamp_o | output | 128 | Timestamps, trigger 1 in bits 63:0, trigger 2 in bits 127:64 |
| alarm_pin_o | output | 2 | Alarm output pins |
| irq_o | output | 1 | Interrupt line |

## Verification
The alarm comparator is driven from a vector table of time pairs, each tried against a fresh alarm value:
- an exact hit,
- a jump over the alarm,
- a stop just short of it,
- a start already past it,
- a time standing still,
- a backward step,
- crossings that ripple into the high half of the time value.

Together these distinguish a crossing test from a plain equality or a plain greater-or-equal test. Trigger capture is tried with a counter that advances every cycle, which pins down the two-stage synchroniser latency. It is also tried with both edge polarities and with a re-capture while the previous event is still pending. Directed sequences cover clear-versus-set collisions, mask selection, alarm re-arming and pin polarity.

// File: rtl/tmr_evt_pkg.sv
// Package: shared register width, write addresses and event/control bit
// positions for the timer event unit. Assumes at most two triggers,
// two alarms and two pulse sources.
package tmr_evt_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_EVT     = 3'd1,
        A_MASK    = 3'd2,
        A_ALM1_LO = 3'd3,
        A_ALM1_HI = 3'd4,
        A_ALM2_LO = 3'd5,
        A_ALM2_HI = 3'd6
    } reg_addr_e;

    function automatic int trig_evt_bit(input int i);
        return 24 + i;
    endfunction

    function automatic int alm_evt_bit(input int i);
        return 16 + i;
    endfunction

    function automatic int pulse_evt_bit(input int i);
        return 7 - i;
    endfunction

    function automatic int trig_pol_bit(input int i);
        return 8 + i;
    endfunction

    function automatic int alm_pol_bit(input int i);
        return 31 - i;
    endfunction

    // Implemented event bits for a given configuration.
    function automatic logic [REG_W-1:0] evt_impl(input int nt, input int na, input int np);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < nt; i++) m[trig_evt_bit(i)] = 1'b1;
        for (int i = 0; i < na; i++) m[alm_evt_bit(i)] = 1'b1;
        for (int i = 0; i < np; i++) m[pulse_evt_bit(i)] = 1'b1;
        return m;
    endfunction

    // Implemented control bits for a given configuration.
    function automatic logic [REG_W-1:0] ctrl_impl(input int nt, input int na);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < nt; i++) m[trig_pol_bit(i)] = 1'b1;
        for (int i = 0; i < na; i++) m[alm_pol_bit(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tmr_trig_capture.sv
// Trigger capture: synchronises one asynchronous trigger pin through
// SYNC_STAGES flops, detects the edge chosen by fall_sel, and latches
// time_now into the stamp register on that edge.
// Assumes the pin is held stable for at least two clock cycles per level.
module tmr_trig_capture #(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              fall_sel,
    input  logic [TIME_W-1:0] time_now,
    output logic              hit,
    output logic [TIME_W-1:0] stamp
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl;

    assign lvl = sync_q[SYNC_STAGES-1];

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Select the active edge.
    always_comb begin
        hit = fall_sel ? (prev_q & ~lvl) : (lvl & ~prev_q);
    end

    // Latch the counter on every active edge, overwriting older values.
    always_ff @(posedge clk) begin
        if (!rst_n)   stamp <= '0;
        else if (hit) stamp <= time_now;
    end

endmodule

// File: rtl/tmr_alarm_cmp.sv
// Alarm comparator: holds a 64-bit alarm loaded in two halves. Writing the
// high half arms it. It fires for one cycle when time crosses the alarm
// (previous time below, current time at or above) and then disarms.
// Assumes time_prev is time_now delayed by one clock.
module tmr_alarm_cmp #(
    parameter int TIME_W = 64,
    localparam int HALF_W = TIME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] time_prev,
    output logic              fire
);

    logic [TIME_W-1:0] alarm_q;
    logic              armed_q;

    // Load the alarm halves from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else begin
            if (ld_lo) alarm_q[HALF_W-1:0]      <= wdata;
            if (ld_hi) alarm_q[TIME_W-1:HALF_W] <= wdata;
        end
    end

    // Detect a crossing of the alarm value while armed.
    always_comb begin
        fire = armed_q && (time_now >= alarm_q) && (time_prev < alarm_q);
    end

    // Arm on a high-half write; disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (ld_hi) armed_q <= 1'b1;
        else if (fire)  armed_q <= 1'b0;
    end

endmodule

// File: rtl/tmr_evt_regs.sv
// Event and mask registers: event bits are set by hardware and cleared by
// write-one; a set wins over a clear in the same cycle. The interrupt is
// the OR of events qualified by the mask. Only bits in IMPL are stored.
module tmr_evt_regs #(
    parameter int                  W    = 32,
    parameter logic [W-1:0]        IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_ld,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] evt_q,
    output logic         irq
);

    logic [W-1:0] mask_q;

    // Update pending events: clear by write-one, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= ((evt_q & ~clr_vec) | set_vec) & IMPL;
    end

    // Hold the interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_ld) mask_q <= mask_wdata & IMPL;
    end

    // Raise the interrupt when any enabled event is pending.
    always_comb begin
        irq = |(evt_q & mask_q);
    end

endmodule

// File: rtl/tmr_event_unit.sv
// Timer event unit top: trigger captures, alarm comparators, pulse event
// collection, control register and event/mask registers. Assumes
// N_TRIG, N_ALM and N_PULSE are each 1 or 2 and TIME_W is 64.
module tmr_event_unit
    import tmr_evt_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int N_TRIG      = 2,
    parameter int N_ALM       = 2,
    parameter int N_PULSE     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = TIME_W / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TIME_W-1:0]        time_now,
    input  logic [N_TRIG-1:0]        trig_in,
    input  logic [N_PULSE-1:0]       pulse_in,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [HALF_W-1:0]        wr_data,
    output logic [REG_W-1:0]         evt_o,
    output logic [N_TRIG*TIME_W-1:0] stamp_o,
    output logic [N_ALM-1:0]         alarm_pin_o,
    output logic                     irq_o
);

    localparam logic [REG_W-1:0] EVT_MASK  = evt_impl(N_TRIG, N_ALM, N_PULSE);
    localparam logic [REG_W-1:0] CTRL_MASK = ctrl_impl(N_TRIG, N_ALM);

    logic [TIME_W-1:0] time_prev_q;
    logic [REG_W-1:0]  ctrl_q;
    logic [N_TRIG-1:0] trig_hit;
    logic [N_ALM-1:0]  alm_fire;
    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  clr_vec;
    logic              mask_ld;

    // Delay the counter by one cycle for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) time_prev_q <= '0;
        else        time_prev_q <= time_now;
    end

    // Hold the polarity control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data & CTRL_MASK;
    end

    generate
        for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
            tmr_trig_capture #(
                .TIME_W      (TIME_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_cap (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (trig_in[t]),
                .fall_sel (ctrl_q[trig_pol_bit(t)]),
                .time_now (time_now),
                .hit      (trig_hit[t]),
                .stamp    (stamp_o[t*TIME_W +: TIME_W])
            );
        end

        for (genvar a = 0; a < N_ALM; a++) begin : g_alm
            tmr_alarm_cmp #(
                .TIME_W (TIME_W)
            ) u_alm (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_lo     (wr_en && wr_addr == 3'(int'(A_ALM1_LO) + 2*a)),
                .ld_hi     (wr_en && wr_addr == 3'(int'(A_ALM1_HI) + 2*a)),
                .wdata     (wr_data),
                .time_now  (time_now),
                .time_prev (time_prev_q),
                .fire      (alm_fire[a])
            );
            // Drive the alarm pin from its pending event and polarity.
            assign alarm_pin_o[a] = evt_o[alm_evt_bit(a)] ^ ctrl_q[alm_pol_bit(a)];
        end
    endgenerate

    // Gather hardware event sources into their bit positions.
    always_comb begin
        set_vec = '0;
        for (int t = 0; t < N_TRIG; t++)  set_vec[trig_evt_bit(t)]  = trig_hit[t];
        for (int a = 0; a < N_ALM; a++)   set_vec[alm_evt_bit(a)]   = alm_fire[a];
        for (int p = 0; p < N_PULSE; p++) set_vec[pulse_evt_bit(p)] = pulse_in[p];
    end

    // Decode the write-one-to-clear and mask strobes.
    always_comb begin
        clr_vec = (wr_en && wr_addr == A_EVT) ? wr_data : '0;
        mask_ld = wr_en && wr_addr == A_MASK;
    end

    tmr_evt_regs #(
        .W    (REG_W),
        .IMPL (EVT_MASK)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_ld    (mask_ld),
        .mask_wdata (wr_data),
        .evt_q      (evt_o),
        .irq        (irq_o)
    );

endmodule

// File: rtl/tmr_event_unit_chk.sv
// Checker for tmr_event_unit: temporal properties on reset, event clearing,
// alarm one-shot behaviour, pulse collection and capture/event pairing.
// Bound to every instance of the top module.
module tmr_event_unit_chk
    import tmr_evt_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int N_TRIG = 2,
    parameter int N_ALM  = 2,
    parameter int N_PULSE = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [2:0]               wr_addr,
    input logic [REG_W-1:0]         wr_data,
    input logic [N_PULSE-1:0]       pulse_in,
    input logic [REG_W-1:0]         evt_o,
    input logic                     irq_o,
    input logic [N_TRIG*TIME_W-1:0] stamp_o,
    input logic [N_ALM-1:0]         alm_fire,
    input logic [N_TRIG-1:0]        trig_hit
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (evt_o == '0 && !irq_o));

    // R4
    stamp_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stamp_o[TIME_W-1:0]) |-> evt_o[trig_evt_bit(0)]);

    // R6
    alm_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_fire[0] && !(wr_en && wr_addr == A_ALM1_HI)) |=> !alm_fire[0]);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EVT && wr_data[trig_evt_bit(0)] && !trig_hit[0])
        |=> !evt_o[trig_evt_bit(0)]);

    // R7
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[alm_evt_bit(0)] && !(wr_en && wr_addr == A_EVT && wr_data[alm_evt_bit(0)]))
        |=> evt_o[alm_evt_bit(0)]);

    // R10
    pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_in[0] |=> evt_o[pulse_evt_bit(0)]);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (evt_o != '0));

endmodule

bind tmr_event_unit tmr_event_unit_chk #(
    .TIME_W  (TIME_W),
    .N_TRIG  (N_TRIG),
    .N_ALM   (N_ALM),
    .N_PULSE (N_PULSE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pulse_in (pulse_in),
    .evt_o    (evt_o),
    .irq_o    (irq_o),
    .stamp_o  (stamp_o),
    .alm_fire (alm_fire),
    .trig_hit (trig_hit)
);

// File: tb/tmr_event_unit_tb.sv
`timescale 1ns/1ps
// Bench for tmr_event_unit: alarm vector table plus directed tests.
module tmr_event_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  tnow = '0;
    logic [1:0]   trig = '0;
    logic [1:0]   pulse = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  evt;
    logic [127:0] stamp;
    logic [1:0]   apin;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    tmr_event_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_now    (tnow),
        .trig_in     (trig),
        .pulse_in    (pulse),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .evt_o       (evt),
        .stamp_o     (stamp),
        .alarm_pin_o (apin),
        .irq_o       (irq)
    );

    // Alarm vectors: alarm value, previous time, new time, expected fire.
    typedef struct packed {
        logic [63:0] alarm;
        logic [63:0] t0;
        logic [63:0] t1;
        logic        fire;
    } avec_t;

    localparam avec_t VEC [8] = '{
        '{64'd100, 64'd99, 64'd100, 1'b1},
        '{64'd100, 64'd100, 64'd101, 1'b0},
        '{64'd100, 64'd90, 64'd130, 1'b1},
        '{64'd100, 64'd50, 64'd99, 1'b0},
        '{64'h1_0000_0005, 64'h0_FFFF_FFFF, 64'h1_0000_0005, 1'b1},
        '{64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFE_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b1},
        '{64'h1_0000_0000, 64'h0_FFFF_FFFF, 64'h0_FFFF_FFFF, 1'b0},
        '{64'd200, 64'd300, 64'd150, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [63:0] v);
        @(negedge clk);
        tnow = v;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 evt", evt, 0);
        check("R1 irq", irq, 0);
        check("R1 stamp", stamp[63:0] | stamp[127:64], 0);
        check("R1 pins", apin, 0);

        // R5 alarm crossing vectors on alarm 1 (event bit 16)
        for (int i = 0; i < 8; i++) begin
            set_time(VEC[i].t0);
            step(1);
            wr(3'd3, VEC[i].alarm[31:0]);
            wr(3'd4, VEC[i].alarm[63:32]);
            wr(3'd1, 32'hFFFF_FFFF);
            set_time(VEC[i].t1);
            step(1);
            check($sformatf("R5 vec%0d", i), evt[16], VEC[i].fire);
        end
        set_time(64'd1000);
        step(1);
        wr(3'd1, 32'hFFFF_FFFF);

        // R3 two-flop latency with a counter advancing each cycle
        @(negedge clk);
        tnow = 64'd1000;
        trig[0] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tnow = tnow + 1;
        end
        check("R3 stamp1", stamp[63:0], 64'd1002);
        check("R2 evt24", evt[24], 1);

        // R2 wrong edge ignored, R4 overwrite while pending
        set_time(64'd5000);
        trig[0] = 1'b0;
        step(4);
        check("R2 fall ignored", stamp[63:0], 64'd1002);
        trig[0] = 1'b1;
        step(4);
        check("R4 overwrite", stamp[63:0], 64'd5000);
        check("R4 evt24", evt[24], 1);

        // R2 falling-edge selection for trigger 2 (control bit 9)
        wr(3'd0, 32'h0000_0200);
        trig[1] = 1'b1;
        step(4);
        check("R2 rise ignored evt25", evt[25], 0);
        check("R2 rise ignored stamp2", stamp[127:64], 0);
        set_time(64'd7777);
        trig[1] = 1'b0;
        step(4);
        check("R2 fall stamp2", stamp[127:64], 64'd7777);
        check("R2 evt25", evt[25], 1);

        // R7 write-one-to-clear
        wr(3'd1, 32'h0);
        check("R7 zero write", evt, 32'h0300_0000);
        wr(3'd1, 32'h0100_0000);
        check("R7 clear24", evt, 32'h0200_0000);

        // R8 mask selection
        wr(3'd2, 32'h0);
        check("R8 mask none", irq, 0);
        wr(3'd2, 32'h0100_0000);
        check("R8 other bit", irq, 0);
        wr(3'd2, 32'h0200_0000);
        check("R8 match", irq, 1);
        wr(3'd1, 32'h0200_0000);
        check("R8 cleared", irq, 0);

        // R10 pulse bits, R7 set wins over clear
        @(negedge clk);
        pulse[0] = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h0000_0080;
        @(negedge clk);
        pulse[0] = 1'b0;
        wr_en = 1'b0;
        check("R7 set wins", evt, 32'h0000_0080);
        @(negedge clk);
        pulse[1] = 1'b1;
        @(negedge clk);
        pulse[1] = 1'b0;
        check("R10 bit6", evt, 32'h0000_00C0);
        wr(3'd1, 32'hFFFF_FFFF);
        check("R7 clear all", evt, 0);

        // R5/R6 alarm 2 one-shot and re-arm
        set_time(64'd400);
        wr(3'd5, 32'd500);
        wr(3'd6, 32'd0);
        set_time(64'd600);
        step(1);
        check("R5 alarm2 fire", evt[17], 1);
        // R9 pin polarity
        check("R9 pin2 active", apin[1], 1);
        wr(3'd0, 32'h4000_0200);
        check("R9 pin2 inverted", apin[1], 0);
        wr(3'd0, 32'h8000_0200);
        check("R9 pins", apin, 2'b11);
        wr(3'd1, 32'h0002_0000);
        set_time(64'd400);
        set_time(64'd600);
        step(1);
        check("R6 no refire", evt[17], 0);
        wr(3'd6, 32'd0);
        set_time(64'd400);
        set_time(64'd600);
        step(1);
        check("R6 rearmed", evt[17], 1);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 evt after reset", evt, 0);
        check("R1 pins after reset", apin, 0);
        check("R1 stamp after reset", stamp[127:64], 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule